// File: doc/BRIEF.md
# TSB Pointer Generator

This block forms the two translation storage buffer entry addresses that miss-handling software loads after a TLB miss. One address serves the 8 KB page size and the other serves the 64 KB page size. The block reads three inputs: a 64-bit TSB configuration word, the faulting virtual address, and a 13-bit context number. The configuration word holds the buffer base, a 4-bit size code N in the range 0 to 15, and a flag that selects split organisation. From the context number the block builds a hash whose width tracks N but stops growing at 13 bits. It XORs that hash into a slice of the virtual address taken at each page size. The result is written into the address below the base bits, in 16-byte entry units.

A one-cycle `capture` strobe registers both addresses from the current inputs. The outputs then keep those values until the next strobe. Reset clears both outputs to zero. Every field boundary is computed from N with masks and shifts, so one datapath handles all sixteen sizes.

Top module: `tsb_ptr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first capture, both `ptr_8k` and `ptr_64k` read zero.
- R2: A high `capture` at a rising clock edge loads both outputs from that cycle's inputs, and they are visible after that edge. While `capture` is low, both outputs keep their value whatever the inputs do.
- R3: The 8 KB index equals `miss_va` bits [21+N:13] XOR the hash, which is N+9 bits wide. It occupies `ptr_8k` bits [12+N:4].
- R4: The 64 KB index equals `miss_va` bits [24+N:16] XOR the hash. It occupies `ptr_64k` bits [12+N:4].
- R5: For N from 0 to 4 the hash is `ctx_id` bits [N+8:0].
- R6: For N from 5 to 15 the hash is `ctx_id` bits [12:0]. Hash bits N+8 down to 13 are zero, so the context never alters index bits at positions 13 and above.
- R7: When `tsb_cfg` bit 12 (split flag) is 1, bit 13+N holds a page-size select, which is 0 in `ptr_8k` and 1 in `ptr_64k`. Bits [63:14+N] of both outputs copy `tsb_cfg` bits [63:14+N].
- R8: When `tsb_cfg` bit 12 is 0 (shared), bits [63:13+N] of both outputs copy `tsb_cfg` bits [63:13+N], and there is no select bit.
- R9: Bits [3:0] of both outputs are always zero.
- R10: N is read from `tsb_cfg` bits [3:0]. The configuration bits below the base boundary, including the size code and the split flag, never appear in an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture | input | 1 | Miss strobe that loads both outputs |
| tsb_cfg | input | 64 | TSB base, split flag (bit 12) and size code N (bits 3:0) |
| miss_va | input | 64 | Faulting virtual address |
| ctx_id | input | 13 | Context number used for the hash |
| ptr_8k | output | 64 | Registered 8 KB entry address |
| ptr_64k | output | 64 | Registered 64 KB entry address |

## Verification
Every input reaches the ports through one register, so a wrong mask, hash width or boundary shows up in the output word one clock after the capture edge. The failure lands in one of three places: the index slice, the select bit or the base bits. A stuck or leaking load enable shows up differently. The outputs change on a cycle with no strobe, and that can be seen on the very next edge. Sweeping every N in both organisations makes each off-by-one in a boundary show at a known bit position.

// File: rtl/tsb_ptr_pkg.sv
package tsb_ptr_pkg;
  localparam int ADDR_W      = 64;
  localparam int CTX_W       = 13;
  localparam int SIZE_W      = 4;
  localparam int SPLIT_POS   = 12;
  localparam int ENTRY_SHIFT = 4;
  localparam int IDX_MIN_W   = 9;
  localparam int SEL_LSB     = 13;
  localparam int VA_LSB_8K   = 13;
  localparam int VA_STEP_64K = 3;
  localparam int N_KINDS     = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  // Mask with the w lowest bits set.
  function automatic addr_t lsb_mask(input int unsigned w);
    if (w >= ADDR_W) lsb_mask = '1;
    else             lsb_mask = (addr_t'(1) << w) - addr_t'(1);
  endfunction

  // Width of the index field for size code n.
  function automatic int unsigned idx_width(input logic [SIZE_W-1:0] n);
    idx_width = int'(n) + IDX_MIN_W;
  endfunction

  // Context hash: the low idx_width bits of the context, capped at CTX_W.
  function automatic logic [CTX_W-1:0] ctx_hash(input logic [CTX_W-1:0] ctx,
                                                input logic [SIZE_W-1:0] n);
    ctx_hash = ctx & CTX_W'(lsb_mask(idx_width(n)));
  endfunction

  // Virtual-address slice XOR hash, trimmed to the index width.
  function automatic addr_t fold_index(input addr_t va, input int unsigned sh,
                                       input logic [CTX_W-1:0] h,
                                       input logic [SIZE_W-1:0] n);
    fold_index = ((va >> sh) ^ addr_t'(h)) & lsb_mask(idx_width(n));
  endfunction

  // Pointer assembly from base word, index, select value and organisation.
  function automatic addr_t build_ptr(input addr_t base, input addr_t idx,
                                      input logic sel, input logic split,
                                      input logic [SIZE_W-1:0] n);
    int unsigned cut;
    addr_t       p;
    cut = SEL_LSB + int'(n);
    if (split) begin
      p = base & ~lsb_mask(cut + 1);
      p = p | (addr_t'(sel) << cut);
    end else begin
      p = base & ~lsb_mask(cut);
    end
    build_ptr = p | (idx << ENTRY_SHIFT);
  endfunction
endpackage

// File: rtl/tsb_ctx_hash.sv
module tsb_ctx_hash
  import tsb_ptr_pkg::*;
#(
  parameter int CW = CTX_W,
  parameter int SW = SIZE_W
) (
  input  logic [CW-1:0] ctx,
  input  logic [SW-1:0] n,
  output logic [CW-1:0] hash
);
  assign hash = ctx_hash(ctx, n);
endmodule

// File: rtl/tsb_index_fold.sv
module tsb_index_fold
  import tsb_ptr_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int CW       = CTX_W,
  parameter int SW       = SIZE_W,
  parameter int VA_SHIFT = VA_LSB_8K
) (
  input  logic [AW-1:0] va,
  input  logic [CW-1:0] hash,
  input  logic [SW-1:0] n,
  output logic [AW-1:0] idx
);
  assign idx = fold_index(va, VA_SHIFT, hash, n);
endmodule

// File: rtl/tsb_ptr_build.sv
module tsb_ptr_build
  import tsb_ptr_pkg::*;
#(
  parameter int   AW      = ADDR_W,
  parameter int   SW      = SIZE_W,
  parameter logic SEL_VAL = 1'b0
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  input  logic          split,
  input  logic [SW-1:0] n,
  output logic [AW-1:0] ptr
);
  assign ptr = build_ptr(base, idx, SEL_VAL, split, n);
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsb_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] tsb_cfg,
  input  logic [ADDR_W-1:0] miss_va,
  input  logic [CTX_W-1:0]  ctx_id,
  output logic [ADDR_W-1:0] ptr_8k,
  output logic [ADDR_W-1:0] ptr_64k
);
  logic [SIZE_W-1:0] size_n;
  logic              split_en;
  logic [CTX_W-1:0]  hash_w;
  logic [ADDR_W-1:0] idx_w [N_KINDS];
  logic [ADDR_W-1:0] ptr_d [N_KINDS];
  logic [ADDR_W-1:0] ptr_q [N_KINDS];
  logic [SIZE_W-1:0] size_q;
  logic              split_q;

  assign size_n   = tsb_cfg[SIZE_W-1:0];
  assign split_en = tsb_cfg[SPLIT_POS];

  tsb_ctx_hash #(.CW(CTX_W), .SW(SIZE_W)) u_hash (
    .ctx(ctx_id), .n(size_n), .hash(hash_w)
  );

  for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
    localparam int   SHIFT_K = VA_LSB_8K + k * VA_STEP_64K;
    localparam logic SEL_K   = (k != 0);

    tsb_index_fold #(.AW(ADDR_W), .CW(CTX_W), .SW(SIZE_W), .VA_SHIFT(SHIFT_K)) u_fold (
      .va(miss_va), .hash(hash_w), .n(size_n), .idx(idx_w[k])
    );

    tsb_ptr_build #(.AW(ADDR_W), .SW(SIZE_W), .SEL_VAL(SEL_K)) u_build (
      .base(tsb_cfg), .idx(idx_w[k]), .split(split_en), .n(size_n), .ptr(ptr_d[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q[k] <= '0;
      else if (capture) ptr_q[k] <= ptr_d[k];
    end

    // R9
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q[k][ENTRY_SHIFT-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= '0;
      split_q <= 1'b0;
    end else if (capture) begin
      size_q  <= size_n;
      split_q <= split_en;
    end
  end

  assign ptr_8k  = ptr_q[0];
  assign ptr_64k = ptr_q[1];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ptr_8k == '0 && ptr_64k == '0));

  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(ptr_8k) && $stable(ptr_64k)));

  // R7
  split_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_q |-> (ptr_64k[SEL_LSB + int'(size_q)] && !ptr_8k[SEL_LSB + int'(size_q)]));

  // R8
  base_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr_8k ^ ptr_64k) >> (SEL_LSB + int'(size_q) + int'(split_q))) == '0);
endmodule

// File: tb/tsb_ptr_gen_bench.sv
module tsb_ptr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capture = 1'b0;
  logic [63:0] tsb_cfg = '0;
  logic [63:0] miss_va = '0;
  logic [12:0] ctx_id = '0;
  logic [63:0] ptr_8k, ptr_64k;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsb_ptr_gen u_tsb_ptr_gen (
    .clk(clk), .rst_n(rst_n), .capture(capture), .tsb_cfg(tsb_cfg),
    .miss_va(miss_va), .ctx_id(ctx_id), .ptr_8k(ptr_8k), .ptr_64k(ptr_64k)
  );

  typedef struct packed {
    logic [63:0] cfg;
    logic [63:0] va;
    logic [12:0] ctx;
    logic [63:0] e8;
    logic [63:0] e64;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{64'hFFFF_FFFF_FFFF_E000, 64'h0, 13'h0, 64'hFFFF_FFFF_FFFF_E000, 64'hFFFF_FFFF_FFFF_E000},
    '{64'hFFFF_FFFF_FFFF_F000, 64'h0, 13'h0, 64'hFFFF_FFFF_FFFF_C000, 64'hFFFF_FFFF_FFFF_E000},
    '{64'h0, 64'h2000, 13'h0, 64'h10, 64'h0},
    '{64'h0, 64'h0, 13'h1FFF, 64'h1FF0, 64'h1FF0},
    '{64'hF, 64'h0, 13'h1FFF, 64'h1FFF0, 64'h1FFF0},
    '{64'h8000_0000_0000_1005, 64'hFFFF_FFFF_FFFF_FFFF, 13'h0,
      64'h8000_0000_0003_FFF0, 64'h8000_0000_0007_FFF0}
  };

  // Bench model: built bit by bit from the requirements.
  function automatic logic [63:0] model(input logic [63:0] cfg, input logic [63:0] va,
                                        input logic [12:0] ctx, input bit big);
    int n, sh, edge_pos;
    bit sp;
    logic [63:0] r;
    n  = int'(cfg[3:0]);
    sp = cfg[12];
    sh = big ? 16 : 13;
    edge_pos = 13 + n;
    r = '0;
    for (int b = 4; b < 64; b++) begin
      if (b < edge_pos) begin
        int j;
        j = b - 4;
        r[b] = va[j + sh] ^ ((j < 13) ? ctx[j] : 1'b0);
      end else if (sp && b == edge_pos) begin
        r[b] = big;
      end else begin
        r[b] = cfg[b];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] cfg, input logic [63:0] va, input logic [12:0] ctx);
    @(negedge clk);
    tsb_cfg = cfg; miss_va = va; ctx_id = ctx; capture = 1'b1;
    @(posedge clk);
    @(negedge clk);
    capture = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] held8, held64;
    // R1: outputs during and right after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset 8k", ptr_8k, 64'h0);
    check("R1 in reset 64k", ptr_64k, 64'h0);
    rst_n = 1'b1;
    tsb_cfg = 64'hFFFF_FFFF_FFFF_F00F; miss_va = '1; ctx_id = '1;
    @(posedge clk); @(negedge clk);
    check("R1 no capture yet", ptr_64k, 64'h0);

    // Table of directed vectors (R3 R4 R5 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      load(VECS[i].cfg, VECS[i].va, VECS[i].ctx);
      check("R3 R7 R8 table 8k", ptr_8k, VECS[i].e8);
      check("R4 R7 R8 table 64k", ptr_64k, VECS[i].e64);
    end

    // R6: wide size, context must not touch index bits at 13 and above
    load(64'h7, 64'h0, 13'h1FFF);
    check("R6 hash cap 8k", ptr_8k, 64'h1FFF0);
    check("R6 hash cap 64k", ptr_64k, 64'h1FFF0);

    // R10: low configuration bits never leak
    load(64'h0000_0000_0000_0FF0, 64'h0, 13'h0);
    check("R10 low cfg bits 8k", ptr_8k, 64'h0);
    check("R10 low cfg bits 64k", ptr_64k, 64'h0);

    // R2: hold without capture
    held8 = ptr_8k; held64 = ptr_64k;
    @(negedge clk);
    tsb_cfg = 64'hDEAD_BEEF_0000_100C; miss_va = 64'h1234_5678_9ABC_DEF0; ctx_id = 13'h0ABC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 hold 8k", ptr_8k, held8);
    check("R2 hold 64k", ptr_64k, held64);
    capture = 1'b1;
    @(posedge clk); @(negedge clk);
    capture = 1'b0;
    check("R2 capture loads", ptr_64k, model(tsb_cfg, miss_va, ctx_id, 1'b1));

    // Sweep every size in both organisations (R3 R4 R5 R6 R7 R8 R9)
    for (int n = 0; n < 16; n++) begin
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < 4; r++) begin
          logic [63:0] c, v;
          logic [12:0] x;
          c = {$urandom, $urandom};
          c[12] = s[0];
          c[3:0] = 4'(n);
          v = {$urandom, $urandom};
          x = 13'($urandom);
          load(c, v, x);
          check(n <= 4 ? "R3 R5 sweep 8k" : "R3 R6 sweep 8k", ptr_8k, model(c, v, x, 1'b0));
          check(s != 0 ? "R4 R7 sweep 64k" : "R4 R8 sweep 64k", ptr_64k, model(c, v, x, 1'b1));
          check("R9 low bits", {60'h0, ptr_8k[3:0] | ptr_64k[3:0]}, 64'h0);
        end
      end
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset 8k", ptr_8k, 64'h0);
    check("R1 mid-run reset 64k", ptr_64k, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule